// File: doc/BRIEF.md
# PSRAM Configuration Register Access Controller

This block sits on the host side of a pseudo-static RAM and carries out single accesses to the memory's two configuration registers. The registers are reached through a dedicated side-band configuration pin rather than through the data array. A request names the register, the direction, the 16-bit write value and the bus mode, which is asynchronous or synchronous. The controller then drives the chip-enable, address-valid, write-enable, output-enable and configuration pins, the two upper address bits and the data bus. After each command it keeps chip enable high for a programmable recovery time before it accepts another request.

Requests enter on a valid/ready handshake. `req_ready` is high only while the controller is idle. A request held with `req_valid` high while the controller is busy simply waits, and the controller takes it on the first edge at which `req_ready` is high. The read result leaves as a one-cycle pulse on `rsp_valid` with the value on `rsp_data`. This output has no back-pressure: the receiver must take it in that cycle. A request that names an illegal register code is taken in and answered with a one-cycle `cmd_err` pulse, and it causes no bus activity.

All timing values are parameters counted in clock cycles. `P_ACC` is the async access length (at least 2). `P_LAT` is the sync latency to the data beat (at least 1). `P_CPH` is the async recovery and `P_CPBH` is the sync recovery (each at least 1).

Top module: `psram_cfg_ctrl`

## Requirements
- R1: Whenever `psram_ce_n` is low, `psram_cre` is high. `psram_cre` is low whenever `psram_ce_n` is high.
- R2: During a command, `psram_a_hi` carries the register code as address bits [19:18]. Code 00 selects the refresh register and code 10 selects the bus-control register.
- R3: A request with `req_sel` equal to 01 or 11 is accepted and produces exactly one `cmd_err` cycle, on the cycle after acceptance. It drives no low level on `psram_ce_n`.
- R4: An asynchronous command holds `psram_ce_n` low for exactly `P_ACC` cycles. A write holds `psram_we_n` low and `psram_dq_oe` high for all of those cycles, with `psram_dq_out` equal to the request data. A read holds `psram_oe_n` low for all of those cycles except the first.
- R5: A synchronous command holds `psram_ce_n` low for exactly `P_LAT`+2 cycles. A write pulses `psram_we_n` low only in the first cycle and drives the data for exactly one final beat cycle. A synchronous read holds `psram_oe_n` low for `P_LAT`+1 cycles.
- R6: `psram_adv_n` goes low for exactly one cycle per command, in the first cycle that `psram_ce_n` is low.
- R7: After a command ends, `psram_ce_n` stays high for at least `P_CPH` cycles if the command was asynchronous and `P_CPBH` cycles if it was synchronous. `req_ready` is low throughout that time.
- R8: A read delivers the value on `psram_dq_in` from its last output-enable cycle on `rsp_data`, together with a `rsp_valid` pulse exactly one cycle long.
- R9: After reset `req_ready` is high and all active-low strobes are high. `req_ready` drops in the cycle after a request is accepted.
- R10: A request held valid during recovery starts its command with no idle gap. The chip-enable high time between the two commands is exactly the recovery time plus one acceptance cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = register set, 0 = register fetch |
| req_sync | input | 1 | 1 = synchronous bus mode |
| req_sel | input | 2 | Register code (00 refresh, 10 bus control) |
| req_wdata | input | 16 | Value to write |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_data | output | 16 | Read result |
| cmd_err | output | 1 | One-cycle illegal-request flag |
| psram_ce_n | output | 1 | Chip enable, active low |
| psram_adv_n | output | 1 | Address valid, active low |
| psram_we_n | output | 1 | Write enable, active low |
| psram_oe_n | output | 1 | Output enable, active low |
| psram_cre | output | 1 | Configuration-register enable |
| psram_a_hi | output | 2 | Address bits [19:18] |
| psram_dq_out | output | 16 | Data driven to the memory |
| psram_dq_oe | output | 1 | Data bus drive enable |
| psram_dq_in | input | 16 | Data returned by the memory |

## Verification
Two events can fall in the same cycle. The first is the end of the recovery timer for one command; the second is acceptance of a request that has been waiting with `req_valid` high. The bench provokes this by issuing a second request straight after the first, in both bus modes, so that the request sits blocked through the whole recovery. It then measures the chip-enable high gap between the two commands, which must equal the recovery time plus one. A read result pulse also coincides with the first recovery cycle, and the bench checks that this pulse is one cycle wide and carries the sampled bus value.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_BEAT,
    ST_RECOV
  } cfg_state_e;

  localparam logic [1:0] SEL_REFRESH = 2'b00;
  localparam logic [1:0] SEL_BUSCTL  = 2'b10;

  typedef struct packed {
    logic       wr;
    logic       sync;
    logic [1:0] sel;
  } cfg_req_t;

endpackage

// File: rtl/cfg_req_decode.sv
module cfg_req_decode
  import psram_cfg_pkg::*;
(
  input  logic [1:0] sel,
  output logic       legal
);

  always_comb begin
    legal = (sel == SEL_REFRESH) || (sel == SEL_BUSCTL);
  end

endmodule

// File: rtl/cfg_phase_timer.sv
module cfg_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R7: the recovery/latency window counts down one step per cycle
  assert_timer_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/cfg_bus_fsm.sv
module cfg_bus_fsm
  import psram_cfg_pkg::*;
#(
  parameter int DW     = 16,
  parameter int CW     = 4,
  parameter int P_ACC  = 4,
  parameter int P_LAT  = 3,
  parameter int P_CPH  = 3,
  parameter int P_CPBH = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  cfg_req_t      req_info,
  input  logic [DW-1:0] req_wdata,
  input  logic          legal,
  output logic          t_load,
  output logic [CW-1:0] t_val,
  input  logic          t_zero,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          cmd_err,
  output logic          ce_n,
  output logic          adv_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          cre,
  output logic [1:0]    a_hi,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);

  cfg_state_e    state_q, state_d;
  cfg_req_t      cur_q;
  logic [DW-1:0] wd_q;
  logic          active, take_rd, accept;

  assign accept = (state_q == ST_IDLE) && req_valid && legal;

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_CMD;
      ST_CMD: begin
        state_d = ST_WAIT;
        t_load  = 1'b1;
        t_val   = cur_q.sync ? CW'(P_LAT - 1) : CW'(P_ACC - 2);
      end
      ST_WAIT: begin
        if (t_zero) begin
          if (cur_q.sync) state_d = ST_BEAT;
          else begin
            state_d = ST_RECOV;
            t_load  = 1'b1;
            t_val   = CW'(P_CPH - 1);
          end
        end
      end
      ST_BEAT: begin
        state_d = ST_RECOV;
        t_load  = 1'b1;
        t_val   = CW'(P_CPBH - 1);
      end
      ST_RECOV: if (t_zero) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign take_rd = !cur_q.wr &&
                   (((state_q == ST_WAIT) && t_zero && !cur_q.sync) ||
                    (state_q == ST_BEAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_q     <= '0;
      wd_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      cmd_err   <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= take_rd;
      cmd_err   <= (state_q == ST_IDLE) && req_valid && !legal;
      if (take_rd) rsp_data <= dq_in;
      if (accept) begin
        cur_q <= req_info;
        wd_q  <= req_wdata;
      end
    end
  end

  assign active    = (state_q == ST_CMD) || (state_q == ST_WAIT) || (state_q == ST_BEAT);
  assign req_ready = (state_q == ST_IDLE);
  assign ce_n      = !active;
  assign cre       = active;
  assign adv_n     = !(state_q == ST_CMD);
  assign a_hi      = active ? cur_q.sel : 2'b00;
  assign we_n      = !(cur_q.wr && ((state_q == ST_CMD) ||
                                    ((state_q == ST_WAIT) && !cur_q.sync)));
  assign oe_n      = !(!cur_q.wr && ((state_q == ST_WAIT) || (state_q == ST_BEAT)));
  assign dq_oe     = cur_q.wr &&
                     ((!cur_q.sync && ((state_q == ST_CMD) || (state_q == ST_WAIT))) ||
                      (cur_q.sync && (state_q == ST_BEAT)));
  assign dq_out    = wd_q;

  // R1: configuration pin high for the whole command
  assert_cre_span_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> cre);
  // R2: only legal register codes reach the address pins
  assert_sel_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> (a_hi[0] == 1'b0));
  // R3: an error flag comes with an idle bus
  assert_err_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> ce_n);
  // R6: address valid is a single-cycle pulse inside chip enable
  assert_adv_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |=> adv_n);
  assert_adv_in_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |-> !ce_n);
  // R7: chip enable may not fall straight after it rose
  assert_ce_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |=> ce_n);
  // R8: read strobe is one cycle wide
  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9: requests only taken with the bus idle
  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ce_n);

endmodule

// File: rtl/psram_cfg_ctrl.sv
module psram_cfg_ctrl
  import psram_cfg_pkg::*;
#(
  parameter int DW     = 16,
  parameter int P_ACC  = 4,
  parameter int P_LAT  = 3,
  parameter int P_CPH  = 3,
  parameter int P_CPBH = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_sync,
  input  logic [1:0]    req_sel,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          cmd_err,
  output logic          psram_ce_n,
  output logic          psram_adv_n,
  output logic          psram_we_n,
  output logic          psram_oe_n,
  output logic          psram_cre,
  output logic [1:0]    psram_a_hi,
  output logic [DW-1:0] psram_dq_out,
  output logic          psram_dq_oe,
  input  logic [DW-1:0] psram_dq_in
);

  localparam int MAX_AL = (P_ACC > P_LAT) ? P_ACC : P_LAT;
  localparam int MAX_RC = (P_CPH > P_CPBH) ? P_CPH : P_CPBH;
  localparam int MAX_C  = (MAX_AL > MAX_RC) ? MAX_AL : MAX_RC;
  localparam int CW     = $clog2(MAX_C + 1);

  cfg_req_t      info;
  logic          legal, t_load, t_zero;
  logic [CW-1:0] t_val;

  assign info = '{wr: req_write, sync: req_sync, sel: req_sel};

  cfg_req_decode u_dec (
    .sel   (req_sel),
    .legal (legal)
  );

  cfg_phase_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  cfg_bus_fsm #(
    .DW(DW), .CW(CW), .P_ACC(P_ACC), .P_LAT(P_LAT),
    .P_CPH(P_CPH), .P_CPBH(P_CPBH)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_info  (info),
    .req_wdata (req_wdata),
    .legal     (legal),
    .t_load    (t_load),
    .t_val     (t_val),
    .t_zero    (t_zero),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .cmd_err   (cmd_err),
    .ce_n      (psram_ce_n),
    .adv_n     (psram_adv_n),
    .we_n      (psram_we_n),
    .oe_n      (psram_oe_n),
    .cre       (psram_cre),
    .a_hi      (psram_a_hi),
    .dq_out    (psram_dq_out),
    .dq_oe     (psram_dq_oe),
    .dq_in     (psram_dq_in)
  );

endmodule

// File: tb/sim_psram_cfg_ctrl.sv
module sim_psram_cfg_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DW     = 16;
  localparam int P_ACC  = 4;
  localparam int P_LAT  = 3;
  localparam int P_CPH  = 3;
  localparam int P_CPBH = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_sync = 1'b0;
  logic [1:0] req_sel = 2'b00;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, cmd_err;
  logic [DW-1:0] rsp_data, dq_out, dq_in;
  logic ce_n, adv_n, we_n, oe_n, cre, dq_oe;
  logic [1:0] a_hi;
  logic [DW-1:0] rd_pat = 16'h0000;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: drives data only while output enable is active
  assign dq_in = (!ce_n && !oe_n) ? rd_pat : 16'h0000;

  psram_cfg_ctrl #(.DW(DW), .P_ACC(P_ACC), .P_LAT(P_LAT), .P_CPH(P_CPH), .P_CPBH(P_CPBH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sync(req_sync), .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cmd_err(cmd_err),
    .psram_ce_n(ce_n), .psram_adv_n(adv_n), .psram_we_n(we_n), .psram_oe_n(oe_n),
    .psram_cre(cre), .psram_a_hi(a_hi), .psram_dq_out(dq_out), .psram_dq_oe(dq_oe),
    .psram_dq_in(dq_in)
  );

  // bus monitor, sampled at the falling edge
  int lowlen = 0, highlen = 0, gap_last = 0, len_last = 0;
  int advcnt = 0, welow = 0, oelow = 0, oecnt = 0, falls = 0;
  int rsp_cnt = 0, err_cnt = 0;
  bit cre_bad = 0, dq_bad = 0;
  logic [1:0] addr_seen = 2'b00;
  logic [DW-1:0] rsp_last = '0, exp_dq = '0;
  logic prev_ce = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ce_n && prev_ce) begin
        gap_last = highlen; lowlen = 0; advcnt = 0; welow = 0;
        oelow = 0; oecnt = 0; falls++;
      end
      if (!ce_n) begin
        lowlen++;
        if (!adv_n) advcnt++;
        if (!we_n) welow++;
        if (!oe_n) oelow++;
        if (dq_oe) begin oecnt++; if (dq_out !== exp_dq) dq_bad = 1; end
        addr_seen = a_hi;
        len_last = lowlen;
      end else begin
        if (!prev_ce) highlen = 0;
        highlen++;
      end
      if (ce_n && cre) cre_bad = 1;
      if (!ce_n && !cre) cre_bad = 1;
      if (rsp_valid) begin rsp_cnt++; rsp_last = rsp_data; end
      if (cmd_err) err_cnt++;
      prev_ce = ce_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input bit wr, input bit sy, input logic [1:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_sync = sy; req_sel = sel; req_wdata = d;
    exp_dq = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready === 1'b1, "R9 ready after reset", req_ready, 1);
    chk(ce_n === 1'b1 && adv_n === 1'b1 && we_n === 1'b1 && oe_n === 1'b1,
        "R9 strobes idle", {ce_n, adv_n, we_n, oe_n}, 15);
    chk(cre === 1'b0 && rsp_valid === 1'b0, "R1 cre low at reset", cre, 0);
  endtask

  task automatic t_async_write();
    cre_bad = 0; dq_bad = 0;
    send(1, 0, 2'b10, 16'hA5C3);
    chk(req_ready === 1'b0, "R9 ready drops after accept", req_ready, 0);
    wait_idle();
    chk(len_last == P_ACC, "R4 async ce length", len_last, P_ACC);
    chk(welow == P_ACC && oecnt == P_ACC, "R4 async we/dq span", welow, P_ACC);
    chk(!dq_bad, "R4 async write data", dq_bad, 0);
    chk(advcnt == 1, "R6 single adv", advcnt, 1);
    chk(addr_seen == 2'b10, "R2 bus-control code", addr_seen, 2);
    chk(!cre_bad, "R1 cre tracks ce", cre_bad, 0);
  endtask

  task automatic t_async_read();
    int r0 = rsp_cnt;
    rd_pat = 16'h3C5A;
    send(0, 0, 2'b00, 16'h0000);
    wait_idle();
    chk(len_last == P_ACC, "R4 async read ce length", len_last, P_ACC);
    chk(oelow == P_ACC - 1, "R4 async oe span", oelow, P_ACC - 1);
    chk(addr_seen == 2'b00, "R2 refresh code", addr_seen, 0);
    chk(rsp_cnt - r0 == 1, "R8 one rsp pulse", rsp_cnt - r0, 1);
    chk(rsp_last == 16'h3C5A, "R8 async read data", rsp_last, 16'h3C5A);
  endtask

  task automatic t_sync_write();
    dq_bad = 0;
    send(1, 1, 2'b10, 16'h1234);
    wait_idle();
    chk(len_last == P_LAT + 2, "R5 sync ce length", len_last, P_LAT + 2);
    chk(welow == 1, "R5 sync we pulse", welow, 1);
    chk(oecnt == 1 && !dq_bad, "R5 one data beat", oecnt, 1);
    chk(advcnt == 1, "R6 single adv sync", advcnt, 1);
  endtask

  task automatic t_sync_read();
    int r0 = rsp_cnt;
    rd_pat = 16'hBEEF;
    send(0, 1, 2'b00, 16'h0000);
    wait_idle();
    chk(len_last == P_LAT + 2, "R5 sync read ce length", len_last, P_LAT + 2);
    chk(oelow == P_LAT + 1, "R5 sync oe span", oelow, P_LAT + 1);
    chk(rsp_cnt - r0 == 1, "R8 sync one pulse", rsp_cnt - r0, 1);
    chk(rsp_last == 16'hBEEF, "R8 sync read data", rsp_last, 16'hBEEF);
  endtask

  task automatic t_error(input logic [1:0] sel);
    int e0 = err_cnt, f0 = falls;
    send(1, 0, sel, 16'hFFFF);
    chk(req_ready === 1'b1, "R3 ready stays high", req_ready, 1);
    repeat (4) @(negedge clk);
    chk(err_cnt - e0 == 1, "R3 one error pulse", err_cnt - e0, 1);
    chk(falls == f0, "R3 no bus activity", falls - f0, 0);
  endtask

  task automatic t_back2back(input bit sy);
    int rec = sy ? P_CPBH : P_CPH;
    send(1, sy, 2'b10, 16'h0F0F);
    send(1, sy, 2'b00, 16'hF0F0);
    wait_idle();
    chk(gap_last == rec + 1, "R10 back-to-back gap", gap_last, rec + 1);
    chk(gap_last >= rec, "R7 min ce high", gap_last, rec);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_async_write();
    t_async_read();
    t_sync_write();
    t_sync_read();
    t_error(2'b01);
    t_error(2'b11);
    t_back2back(1'b0);
    t_back2back(1'b1);
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      report();
    end
  end

endmodule